// File: doc/BRIEF.md
# Prescaled PWM Period Generator

This block is a single-channel pulse-width-modulation timebase. An input clock is first divided by a programmable prescaler. A step counter then counts the divided ticks, and one output period is made of a programmable number of steps. A duty setting chooses how many steps of each period the output is held high. All three settings are 8-bit values. The prescaler and the step count each act as the stored value plus one. A full period therefore lasts (divider + 1) * (span + 1) input clock cycles, which is at most 0x10000 cycles.

Software-side logic writes the three settings through separate write strobes. Each write lands in a staging register. The running configuration is replaced only at a period boundary, so every period is generated with one consistent set of values. A one-cycle strobe marks the first cycle of every period. Downstream logic can use it to align sampling or updates.

When the span holds its largest value, no duty value can keep the output high for the whole period. With any smaller span, a duty above the span gives a constant-high output.

Top module: `pwm_timebase`

## Requirements
- R1: The step counter advances once every (divider + 1) input clock cycles, so a period with divider 4 and span 3 holds each step for 5 cycles.
- R2: The distance between consecutive period-start strobes is (divider + 1) * (span + 1) cycles; with divider 0xFF and span 0xFF it is 65536 cycles.
- R3: `pwm_out` is high while the current step index is less than the duty value, so the high time per period is min(duty, span + 1) * (divider + 1) cycles.
- R4: A duty value of 0 keeps `pwm_out` low for the entire period.
- R5: A duty value greater than the span keeps `pwm_out` high for the entire period. With span 0xFF, even duty 0xFF leaves one step (divider + 1 cycles) low, while span 0xFE and duty 0xFF give a constant-high output.
- R6: Writes to divider, span or duty are staged. The period in progress finishes with its old settings, and the new settings apply from the next period start. A write in the same cycle as the period wrap is applied at that wrap.
- R7: While `rst` is high (synchronous, active high), `pwm_out` and `period_start` are low. Reset also clears the counters and all staged and running settings to 0, so after release the period is 1 cycle with the output low.
- R8: `period_start` is high for exactly one cycle, in the first cycle of each period. When the period is longer than one cycle, it is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| div_we | input | 1 | Write strobe for the prescaler divider |
| div_wdata | input | 8 | New divider value (divides by value + 1) |
| span_we | input | 1 | Write strobe for the period span |
| span_wdata | input | 8 | New span value (period holds value + 1 steps) |
| duty_we | input | 1 | Write strobe for the duty value |
| duty_wdata | input | 8 | New duty value in steps |
| period_start | output | 1 | One-cycle strobe in the first cycle of each period |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench builds the block with its default 8-bit setting width. This lets it drive both settings to their extremes. It measures the full 65536-cycle maximum period and shows that a span of 0xFF leaves one step low while 0xFE reaches constant high. A table of small divider and span pairs measures period length and high time between strobes. Directed tests then cover a duty write in the middle of a period, a reset in the middle of a period, and the strobe width.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PWM_REG_W = 8;

  typedef struct packed {
    logic [PWM_REG_W-1:0] div;
    logic [PWM_REG_W-1:0] span;
    logic [PWM_REG_W-1:0] duty;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_shadow_cfg.sv
module pwm_shadow_cfg
  import pwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 div_we,
  input  logic [PWM_REG_W-1:0] div_wdata,
  input  logic                 span_we,
  input  logic [PWM_REG_W-1:0] span_wdata,
  input  logic                 duty_we,
  input  logic [PWM_REG_W-1:0] duty_wdata,
  input  logic                 wrap,
  output pwm_cfg_t             act_q,
  output pwm_cfg_t             act_d
);
  pwm_cfg_t staged_q, staged_d;

  always_comb begin
    staged_d = staged_q;
    if (div_we)  staged_d.div  = div_wdata;
    if (span_we) staged_d.span = span_wdata;
    if (duty_we) staged_d.duty = duty_wdata;
    act_d = wrap ? staged_d : act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q <= '0;
      act_q    <= '0;
    end else begin
      staged_q <= staged_d;
      act_q    <= act_d;
    end
  end

  // R6: running settings change only at a period wrap
  assert_hold_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_q));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int W = PWM_REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] div_lim,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == div_lim);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R1: divider count never passes its limit
  assert_div_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= div_lim);
endmodule

// File: rtl/pwm_step_counter.sv
module pwm_step_counter
  import pwm_pkg::*;
#(
  parameter int W = PWM_REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] span_lim,
  output logic [W-1:0] step_q,
  output logic [W-1:0] step_d,
  output logic         wrap
);
  logic at_end;

  assign at_end = (step_q == span_lim);
  assign wrap   = tick && at_end;

  always_comb begin
    step_d = step_q;
    if (tick) step_d = at_end ? '0 : step_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end

  // R2: step index stays within the span
  assert_step_bound_R2: assert property (@(posedge clk) disable iff (rst)
    step_q <= span_lim);
  // R1: step index moves only on a prescaled tick
  assert_step_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(step_q));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 div_we,
  input  logic [PWM_REG_W-1:0] div_wdata,
  input  logic                 span_we,
  input  logic [PWM_REG_W-1:0] span_wdata,
  input  logic                 duty_we,
  input  logic [PWM_REG_W-1:0] duty_wdata,
  output logic                 period_start,
  output logic                 pwm_out
);
  pwm_cfg_t             act_q, act_d;
  logic                 tick, wrap;
  logic [PWM_REG_W-1:0] step_q, step_d;

  pwm_shadow_cfg u_cfg (
    .clk(clk), .rst(rst),
    .div_we(div_we), .div_wdata(div_wdata),
    .span_we(span_we), .span_wdata(span_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .wrap(wrap), .act_q(act_q), .act_d(act_d)
  );

  pwm_prescaler #(.W(PWM_REG_W)) u_div (
    .clk(clk), .rst(rst), .div_lim(act_q.div), .tick(tick)
  );

  pwm_step_counter #(.W(PWM_REG_W)) u_step (
    .clk(clk), .rst(rst), .tick(tick), .span_lim(act_q.span),
    .step_q(step_q), .step_d(step_d), .wrap(wrap)
  );

  // Output and strobe are registered from next-state values so they line
  // up with the counter state they describe.
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out      <= 1'b0;
      period_start <= 1'b0;
    end else begin
      pwm_out      <= (step_d < act_d.duty);
      period_start <= wrap;
    end
  end

  // R4: zero duty never drives the output high
  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (rst)
    (act_q.duty == '0) |-> !pwm_out);
  // R5: duty above the span holds the output high
  assert_full_duty_R5: assert property (@(posedge clk) disable iff (rst)
    (act_q.duty > act_q.span) |-> pwm_out);
  // R8: strobe lasts one cycle when the period is longer than one cycle
  assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (period_start && (act_q.div != '0 || act_q.span != '0)) |=> !period_start);
  // R7: reset drives both outputs low
  assert_reset_low_R7: assert property (@(posedge clk)
    rst |=> (!pwm_out && !period_start));
endmodule

// File: tb/pwm_timebase_tb_top.sv
module pwm_timebase_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       div_we = 1'b0, span_we = 1'b0, duty_we = 1'b0;
  logic [7:0] div_wdata = '0, span_wdata = '0, duty_wdata = '0;
  logic       period_start, pwm_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_timebase dut_i (
    .clk(clk), .rst(rst),
    .div_we(div_we), .div_wdata(div_wdata),
    .span_we(span_we), .span_wdata(span_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .period_start(period_start), .pwm_out(pwm_out)
  );

  // divider, span, duty, expected period, expected high cycles
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{0,   0,   0,   1,   0},   // R2 R4
    '{0,   9,   3,   10,  3},   // R3
    '{2,   4,   5,   15,  15},  // R5 duty = span+1
    '{1,   7,   200, 16,  16},  // R5
    '{3,   5,   0,   24,  0},   // R4
    '{4,   3,   2,   20,  10},  // R1 R3
    '{0,   255, 255, 256, 255}, // R5 span 0xFF
    '{0,   254, 255, 255, 255}  // R5 span 0xFE
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_all(input int d, input int s, input int u);
    div_wdata = 8'(d); span_wdata = 8'(s); duty_wdata = 8'(u);
    div_we = 1'b1; span_we = 1'b1; duty_we = 1'b1;
    @(negedge clk);
    div_we = 1'b0; span_we = 1'b0; duty_we = 1'b0;
  endtask

  task automatic wait_strobe();
    int n = 0;
    while (!period_start && n < 70000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Called at a negedge where period_start is high; returns at the next one.
  task automatic measure(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      len++;
      if (pwm_out) hi++;
      @(negedge clk);
      div_we = 1'b0; span_we = 1'b0; duty_we = 1'b0;
    end while (!period_start && len < 70000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int len, hi;
    // R7: outputs low during reset
    repeat (3) @(negedge clk);
    check("R7 pwm_out in reset", int'(pwm_out), 0);
    check("R7 period_start in reset", int'(period_start), 0);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      write_all(VEC[i][0], VEC[i][1], VEC[i][2]);
      wait_strobe();
      measure(len, hi);
      check($sformatf("R2 period vec%0d", i), len, VEC[i][3]);
      check($sformatf("R3 high vec%0d", i), hi, VEC[i][4]);
    end

    // R8: strobe is a single cycle
    write_all(0, 9, 3);
    wait_strobe();
    @(negedge clk);
    check("R8 strobe width", int'(period_start), 0);
    wait_strobe();

    // R6: duty write at the start of a period waits for the next one
    duty_wdata = 8'd8; duty_we = 1'b1;
    measure(len, hi);
    check("R6 current period length", len, 10);
    check("R6 current period keeps old duty", hi, 3);
    measure(len, hi);
    check("R6 next period uses new duty", hi, 8);

    // R7: reset in mid-period
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 pwm_out after mid reset", int'(pwm_out), 0);
    check("R7 period_start after mid reset", int'(period_start), 0);
    rst = 1'b0;
    wait_strobe();
    measure(len, hi);
    check("R7 period after reset", len, 1);
    check("R7 high after reset", hi, 0);

    // R2: maximum period 0x10000, R5 one step low at span 0xFF
    write_all(255, 255, 255);
    wait_strobe();
    measure(len, hi);
    check("R2 max period", len, 65536);
    check("R5 max span one step low", hi, 65280);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule